// File: doc/BRIEF.md
# Tag-Indexed Read Completion Reassembler

This block sits between an engine that issues non-posted read requests and a sink that needs the returned data in the order the requests were made. For each request it hands out a 3-bit tag and records how many data beats the request will return. Completion data comes back one beat per cycle, and each beat carries the tag of the request it answers. One answer may be split into several segments. Segments of different requests may interleave in any way, but within one tag the beats arrive in ascending order.

Each beat is written into a buffer owned by its tag, at that tag's write position. A request's data is released only once every one of its beats has arrived. Release follows issue order, so a later request that finishes first waits behind the oldest one. When the final beat of a request is taken downstream, its tag goes back to the free pool. Beats for tags that are not outstanding are dropped and raise a sticky flag.

The requester holds `req_valid` and `req_len` until it sees either `req_grant` or `req_bad`. Lengths are counted in beats of `DATA_W` bits.

Top module: `rcr_reassembler`

## Requirements
- R1: After reset, `out_valid` and `err_flag` are 0 and all eight tags are free.
- R2: A request is granted, in the same cycle, when `req_len` is between 1 and `DEPTH` and a tag is free. The tag handed out is the lowest-numbered free tag, shown on `req_tag`.
- R3: A request with `req_len` of 0 or greater than `DEPTH` raises `req_bad`, is not granted, and consumes no tag.
- R4: While eight tags are outstanding, no request is granted. At every cycle, the number of free tags plus the number of queued tags equals eight.
- R5: Beats for one tag are stored in arrival order, whatever beats of other tags arrive between them.
- R6: No beat of a request appears on the output until all `req_len` beats of that request have arrived.
- R7: Requests drain strictly in issue order, even when a later request completes first.
- R8: Each output beat carries its request's tag on `out_tag`. `out_last` is 1 exactly on the request's final beat.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_tag` and `out_last` hold their values.
- R10: The tag of a request whose final beat is accepted is free in the next cycle and can be granted then.
- R11: A beat whose tag is not outstanding, or that exceeds its request's length, is dropped and never output. It sets `err_flag`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_len | input | LEN_W | Beats the request expects |
| req_grant | output | 1 | Request accepted this cycle |
| req_bad | output | 1 | Request length out of range |
| req_tag | output | 3 | Tag assigned to the granted request |
| cpl_valid | input | 1 | Completion beat present |
| cpl_tag | input | 3 | Tag carried by the completion beat |
| cpl_data | input | DATA_W | Completion beat data |
| out_valid | output | 1 | Ordered output beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | DATA_W | Output beat data |
| out_tag | output | 3 | Tag of the draining request |
| out_last | output | 1 | Final beat of the request |
| err_flag | output | 1 | Sticky flag for dropped beats |

## Verification
The bench interleaves beats across three requests and lets the two younger requests finish before the oldest. If the design steered beats by arrival order instead of by tag, it would output scrambled data. If it released buffers as they completed, it would output them out of order. The bench fills all eight tags, then recycles one tag the cycle after its last beat. A pool that frees tags late would withhold that grant, and one that frees them early would overwrite a buffer still in use. Lengths of 0, `DEPTH` and `DEPTH+1` are also tried, as are a stray beat and an excess beat. A wrong range test would lose a tag, and a design that counted an excess beat would emit data that was never requested.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned RCR_NTAG  = 8;
  localparam int unsigned RCR_TAG_W = 3;
  typedef logic [RCR_TAG_W-1:0] tag_t;
endpackage

// File: rtl/rcr_tag_pool.sv
module rcr_tag_pool
  import rcr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic                rel_en,
  input  tag_t                rel_tag,
  output logic                any_free,
  output tag_t                free_tag,
  output logic [RCR_NTAG-1:0] free_vec
);
  logic [RCR_NTAG-1:0] free_d;

  // lowest-numbered free tag wins
  always_comb begin
    free_tag = '0;
    for (int i = RCR_NTAG - 1; i >= 0; i--) begin
      if (free_vec[i]) free_tag = tag_t'(i);
    end
    any_free = |free_vec;
  end

  always_comb begin
    free_d = free_vec;
    if (alloc_en) free_d[free_tag] = 1'b0;
    if (rel_en)   free_d[rel_tag]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_vec <= '1;
    else        free_vec <= free_d;
  end
endmodule

// File: rtl/rcr_order_q.sv
module rcr_order_q
  import rcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  tag_t               push_tag,
  input  logic               pop_en,
  output tag_t               head_tag,
  output logic               not_empty,
  output logic [RCR_TAG_W:0] count
);
  tag_t               slot_q [RCR_NTAG];
  tag_t               wp_q, rp_q, wp_d, rp_d;
  logic [RCR_TAG_W:0] cnt_d;

  always_comb begin
    wp_d  = push_en ? wp_q + tag_t'(1) : wp_q;
    rp_d  = pop_en  ? rp_q + tag_t'(1) : rp_q;
    cnt_d = count + (RCR_TAG_W+1)'(push_en) - (RCR_TAG_W+1)'(pop_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) slot_q[wp_q] <= push_tag;
  end

  assign head_tag  = slot_q[rp_q];
  assign not_empty = (count != '0);
endmodule

// File: rtl/rcr_tag_store.sv
module rcr_tag_store
  import rcr_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LEN_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  tag_t              alloc_tag,
  input  logic [LEN_W-1:0]  alloc_len,
  input  logic              wr_en,
  input  tag_t              wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ok,
  input  logic              rel_en,
  input  tag_t              rel_tag,
  input  tag_t              rd_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_done,
  output logic [LEN_W-1:0]  rd_len,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned WORDS  = RCR_NTAG * DEPTH;
  localparam int unsigned ADDR_W = $clog2(WORDS);

  logic [LEN_W-1:0]    exp_q [RCR_NTAG];
  logic [LEN_W-1:0]    exp_d [RCR_NTAG];
  logic [LEN_W-1:0]    rcv_q [RCR_NTAG];
  logic [LEN_W-1:0]    rcv_d [RCR_NTAG];
  logic [RCR_NTAG-1:0] act_q, act_d;
  logic [DATA_W-1:0]   mem [WORDS];
  logic [ADDR_W-1:0]   waddr, raddr;
  logic                wr_do;

  assign wr_ok = act_q[wr_tag] && (rcv_q[wr_tag] != exp_q[wr_tag]);
  assign wr_do = wr_en && wr_ok;
  assign waddr = ADDR_W'(wr_tag) * ADDR_W'(DEPTH) + ADDR_W'(rcv_q[wr_tag]);
  assign raddr = ADDR_W'(rd_tag) * ADDR_W'(DEPTH) + ADDR_W'(rd_idx);

  always_comb begin
    exp_d = exp_q;
    rcv_d = rcv_q;
    act_d = act_q;
    if (alloc_en) begin
      exp_d[alloc_tag] = alloc_len;
      rcv_d[alloc_tag] = '0;
      act_d[alloc_tag] = 1'b1;
    end
    if (wr_do)  rcv_d[wr_tag] = rcv_q[wr_tag] + LEN_W'(1);
    if (rel_en) act_d[rel_tag] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int i = 0; i < RCR_NTAG; i++) begin
        exp_q[i] <= '0;
        rcv_q[i] <= '0;
      end
    end else begin
      act_q <= act_d;
      exp_q <= exp_d;
      rcv_q <= rcv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_do) mem[waddr] <= wr_data;
  end

  assign rd_done = act_q[rd_tag] && (rcv_q[rd_tag] == exp_q[rd_tag]);
  assign rd_len  = exp_q[rd_tag];
  assign rd_data = mem[raddr];
endmodule

// File: rtl/rcr_reassembler.sv
module rcr_reassembler
  import rcr_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LEN_W  = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_grant,
  output logic              req_bad,
  output logic [2:0]        req_tag,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        out_tag,
  output logic              out_last,
  output logic              err_flag
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                any_free;
  tag_t                free_tag;
  logic [RCR_NTAG-1:0] free_vec;
  tag_t                head_tag;
  logic                q_ne;
  logic [RCR_TAG_W:0]  q_count;
  logic                wr_ok, rd_done;
  logic [LEN_W-1:0]    rd_len;
  logic [IDX_W-1:0]    rd_idx_q, rd_idx_d;
  logic                len_bad, fire, fin, err_d;

  assign len_bad   = (req_len == '0) || (req_len > LEN_W'(DEPTH));
  assign req_bad   = req_valid && len_bad;
  assign req_grant = req_valid && !len_bad && any_free;
  assign req_tag   = free_tag;

  rcr_tag_pool pool_i (
    .clk(clk), .rst_n(rst_n), .alloc_en(req_grant),
    .rel_en(fin), .rel_tag(head_tag),
    .any_free(any_free), .free_tag(free_tag), .free_vec(free_vec)
  );

  rcr_order_q order_i (
    .clk(clk), .rst_n(rst_n), .push_en(req_grant), .push_tag(free_tag),
    .pop_en(fin), .head_tag(head_tag), .not_empty(q_ne), .count(q_count)
  );

  rcr_tag_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(req_grant), .alloc_tag(free_tag), .alloc_len(req_len),
    .wr_en(cpl_valid), .wr_tag(cpl_tag), .wr_data(cpl_data), .wr_ok(wr_ok),
    .rel_en(fin), .rel_tag(head_tag),
    .rd_tag(head_tag), .rd_idx(rd_idx_q),
    .rd_done(rd_done), .rd_len(rd_len), .rd_data(out_data)
  );

  assign out_valid = q_ne && rd_done;
  assign out_tag   = head_tag;
  assign out_last  = (LEN_W'(rd_idx_q) == rd_len - LEN_W'(1));
  assign fire      = out_valid && out_ready;
  assign fin       = fire && out_last;

  always_comb begin
    rd_idx_d = rd_idx_q;
    if (fin)       rd_idx_d = '0;
    else if (fire) rd_idx_d = rd_idx_q + IDX_W'(1);
    err_d = err_flag | (cpl_valid && !wr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q <= '0;
      err_flag <= 1'b0;
    end else begin
      rd_idx_q <= rd_idx_d;
      err_flag <= err_d;
    end
  end
endmodule

// File: rtl/rcr_reassembler_chk.sv
module rcr_reassembler_chk
  import rcr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
)(
  input logic                clk,
  input logic                rst_n,
  input logic                req_grant,
  input logic [2:0]          req_tag,
  input logic                cpl_valid,
  input logic [2:0]          cpl_tag,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_data,
  input logic [2:0]          out_tag,
  input logic                out_last,
  input logic                err_flag,
  input logic [RCR_NTAG-1:0] free_vec,
  input logic [RCR_TAG_W:0]  q_count
);
  // R2
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |-> free_vec[req_tag]);

  // R4
  tag_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(free_vec) + int'(q_count)) == RCR_NTAG);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_tag) && $stable(out_last)));

  // R10
  tag_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> free_vec[$past(out_tag)]);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R11
  stray_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && free_vec[cpl_tag]) |=> err_flag);
endmodule

bind rcr_reassembler rcr_reassembler_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_grant(req_grant), .req_tag(req_tag),
  .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_tag(out_tag), .out_last(out_last), .err_flag(err_flag),
  .free_vec(free_vec), .q_count(q_count)
);

// File: tb/rcr_reassembler_tb.sv
module rcr_reassembler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [LEN_W-1:0]  req_len;
  logic              req_grant, req_bad;
  logic [2:0]        req_tag;
  logic              cpl_valid;
  logic [2:0]        cpl_tag;
  logic [DATA_W-1:0] cpl_data;
  logic              out_valid, out_ready, out_last, err_flag;
  logic [DATA_W-1:0] out_data;
  logic [2:0]        out_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcr_reassembler #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_grant(req_grant), .req_bad(req_bad), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .out_last(out_last), .err_flag(err_flag)
  );

  function automatic logic [DATA_W-1:0] pat(int tag, int idx);
    return DATA_W'(32'hC0DE_0000 + tag * 256 + idx);
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(int len, int exp_tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = LEN_W'(len);
    #1;
    chk("R2 grant", DATA_W'(req_grant), 1);
    chk("R2 tag", DATA_W'(req_tag), DATA_W'(exp_tag));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic beat(int tag, int idx);
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_tag   = 3'(tag);
    cpl_data  = pat(tag, idx);
    @(posedge clk);
    #1 cpl_valid = 1'b0;
  endtask

  task automatic drain(int tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      chk("R6 out_valid", DATA_W'(out_valid), 1);
      chk("R5 data", out_data, pat(tag, i));
      chk("R7 R8 tag", DATA_W'(out_tag), DATA_W'(tag));
      chk("R8 last", DATA_W'(out_last), DATA_W'(i == n - 1));
      @(posedge clk);
      #1 out_ready = 1'b0;
    end
  endtask

  task automatic expect_idle(string req);
    @(negedge clk);
    chk(req, DATA_W'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", DATA_W'(out_valid), 0);
    chk("R1 err_flag", DATA_W'(err_flag), 0);
  endtask

  task automatic t_sequential;
    issue(2, 0); issue(3, 1); issue(1, 2);
    for (int i = 0; i < 2; i++) beat(0, i);
    for (int i = 0; i < 3; i++) beat(1, i);
    beat(2, 0);
    drain(0, 2); drain(1, 3); drain(2, 1);
  endtask

  task automatic t_interleaved;
    issue(3, 0); issue(3, 1); issue(3, 2);
    for (int i = 0; i < 2; i++) begin
      beat(0, i); beat(1, i); beat(2, i);
    end
    expect_idle("R6 partial held");
    beat(2, 2); beat(1, 2);
    expect_idle("R7 younger done first");
    beat(0, 2);
    drain(0, 3); drain(1, 3); drain(2, 3);
  endtask

  task automatic t_stall;
    issue(2, 0);
    beat(0, 0); beat(0, 1);
    @(negedge clk);
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 valid held", DATA_W'(out_valid), 1);
      chk("R9 data held", out_data, pat(0, 0));
    end
    drain(0, 2);
  endtask

  task automatic t_full_pool;
    for (int t = 0; t < 8; t++) issue(1, t);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = LEN_W'(1);
    #1 chk("R4 no grant when full", DATA_W'(req_grant), 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
    beat(0, 0);
    drain(0, 1);
    issue(1, 0);   // R10 tag 0 reusable on the next cycle
    for (int t = 1; t < 8; t++) beat(t, 0);
    beat(0, 0);
    for (int t = 1; t < 8; t++) drain(t, 1);
    drain(0, 1);
  endtask

  task automatic t_bad_len;
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = '0;
    #1;
    chk("R3 len0 bad", DATA_W'(req_bad), 1);
    chk("R3 len0 no grant", DATA_W'(req_grant), 0);
    @(negedge clk);
    req_len = LEN_W'(DEPTH + 1);
    #1;
    chk("R3 oversize bad", DATA_W'(req_bad), 1);
    chk("R3 oversize no grant", DATA_W'(req_grant), 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
    issue(DEPTH, 0);   // R3 no tag consumed: still tag 0
    for (int i = 0; i < DEPTH; i++) beat(0, i);
    drain(0, DEPTH);
  endtask

  task automatic t_stray;
    chk("R11 err clear before", DATA_W'(err_flag), 0);
    beat(5, 0);
    @(negedge clk);
    chk("R11 stray sets err", DATA_W'(err_flag), 1);
    chk("R11 stray not output", DATA_W'(out_valid), 0);
    issue(1, 0);
    beat(0, 0);
    beat(0, 1);    // R11 excess beat dropped
    drain(0, 1);
    expect_idle("R11 excess not output");
    repeat (3) @(negedge clk);
    chk("R11 err sticky", DATA_W'(err_flag), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_len = '0;
    cpl_valid = 1'b0; cpl_tag = '0; cpl_data = '0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sequential();
    t_interleaved();
    t_stall();
    t_full_pool();
    t_bad_len();
    t_stray();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule